// File: doc/BRIEF.md
# Serial Card Host Interrupt Status Register

This block holds the interrupt status and control word of a serial memory-card host. Six event sources are gathered into one status byte: transfer ready, serial-interface interrupt, data-transfer request, parallel-input change, FIFO access error and CRC error. Each bit is set by a one-cycle event pulse from the protocol engine, the FIFO or the pin monitor. Each bit is cleared by its own side effect: an accepted command write, a FIFO access in the direction of the current command, a read of the parallel-pin register, or a read of the FIFO-error register.

A single level-high interrupt line is raised when any status bit rises from 0 to 1 while interrupts are enabled. A read of this register while interrupts are enabled withdraws the request without touching the status bits. A CRC error also forces the ready bit high and holds the bus-state line low until the next accepted command. Three control bits live in the same word: interrupt enable, data-request select and FIFO-error enable. The register is read combinationally. Writes reach only the control bits.

Top module: `sc_irq_status`

## Requirements
- R1: After reset the register reads 0x0080: ready is 1, every other status bit is 0 and the control bits are 0. `irq_o`, `dma_req_o` and `cmd_go_o` are 0.
- R2: The ready bit sits at bit 7 and reads 1 when idle. A command write while ready=1 pulses `cmd_go_o` in the same cycle and clears ready, SIF (bit 6) and CRC (bit 1). A command write while ready=0 is ignored: `cmd_go_o` stays 0 and no bit changes.
- R3: A `done_i` pulse sets ready. The next cycle `irq_o` is 1 when the interrupt enable (bit 15) is 1.
- R4: A `sif_i` pulse sets SIF (bit 6) and raises `irq_o`.
- R5: The data-request bit (bit 5) changes only while data-request select (bit 14) is 1. Once set, it is cleared by `fifo_wr_i` when `cmd_is_read_i`=0, or by `fifo_rd_i` when `cmd_is_read_i`=1. A FIFO access in the other direction has no effect.
- R6: `dma_req_o` is 1 exactly when the data-request bit is 1 and `dma_en_i` is 1.
- R7: A change in the level of any `pins_i` line sets the parallel-input bit (bit 4). `pin_rd_i` clears it.
- R8: `fae_i` sets the FIFO-error bit (bit 2) only while FIFO-error enable (bit 13) is 1. `fae_rd_i` clears it.
- R9: `crc_err_i` sets the CRC bit (bit 1), sets ready and raises `irq_o`. `bs_o` is 0 while the CRC bit is 1 and follows `bs_i` otherwise.
- R10: A status read while the interrupt enable is 1 drops `irq_o` on the next cycle and leaves the status bits unchanged. A later new 0-to-1 status transition raises `irq_o` again.
- R11: When a bit's set event and its clear action come in the same cycle, the bit ends up 1.
- R12: Bits 12..8, 3 and 0 always read 0. A status write changes only bits 15..13.
- R13: While the interrupt enable is 0, `irq_o` is 0 and a status read does not withdraw pending requests. Setting the enable afterwards raises `irq_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sts_rd_i | input | 1 | Read strobe for this register |
| sts_wr_i | input | 1 | Write strobe for this register |
| wdata_i | input | 16 | Write data; only bits 15..13 are used |
| rdata_o | output | 16 | Register read value |
| cmd_wr_i | input | 1 | Command register write attempt |
| cmd_go_o | output | 1 | Command write was accepted |
| cmd_is_read_i | input | 1 | Current command moves data from the card |
| fifo_wr_i | input | 1 | FIFO write access |
| fifo_rd_i | input | 1 | FIFO read access |
| pin_rd_i | input | 1 | Read of the parallel-pin register |
| fae_rd_i | input | 1 | Read of the FIFO-error register |
| done_i | input | 1 | Protocol end event |
| sif_i | input | 1 | Serial-interface interrupt event |
| drq_i | input | 1 | Data-transfer request event |
| fae_i | input | 1 | FIFO access error event |
| crc_err_i | input | 1 | CRC error event |
| pins_i | input | PIN_W | Synchronised parallel input pins |
| dma_en_i | input | 1 | DMA request enable |
| dma_req_o | output | 1 | DMA request |
| bs_i | input | 1 | Bus-state level from the protocol engine |
| bs_o | output | 1 | Bus-state line to the card |
| irq_o | output | 1 | Interrupt request, level high |

## Verification
The assertions assume that every event and access input is a single-cycle strobe that is synchronous to `clk_i`, and that `pins_i` has already been synchronised. The stimulus applies every strobe for exactly one clock, changing it on the falling edge, so each event sits on exactly one rising edge. The stimulus also raises `done_i` only while a transfer is running and holds `pins_i` steady through reset, so the pin monitor takes its first sample as a baseline rather than as a change. Same-cycle set and clear cases are applied on purpose to exercise the set-wins rule.

// File: rtl/sc_irq_pkg.sv
package sc_irq_pkg;
  localparam int unsigned REG_W = 16;
  localparam int unsigned NSRC  = 6;

  // source index into the internal status vector
  localparam int unsigned S_CRC = 0;
  localparam int unsigned S_FAE = 1;
  localparam int unsigned S_PIN = 2;
  localparam int unsigned S_DRQ = 3;
  localparam int unsigned S_SIF = 4;
  localparam int unsigned S_RDY = 5;

  // register bit positions
  localparam int unsigned P_CRC    = 1;
  localparam int unsigned P_FAE    = 2;
  localparam int unsigned P_PIN    = 4;
  localparam int unsigned P_DRQ    = 5;
  localparam int unsigned P_SIF    = 6;
  localparam int unsigned P_RDY    = 7;
  localparam int unsigned P_FAE_EN = 13;
  localparam int unsigned P_DRQ_SL = 14;
  localparam int unsigned P_IRQ_EN = 15;

  localparam logic [NSRC-1:0] SRC_RST = NSRC'(1) << S_RDY;

  typedef struct packed {
    logic irq_en;
    logic drq_sel;
    logic fae_en;
  } ctrl_t;

  function automatic logic [REG_W-1:0] pack_reg(input ctrl_t c, input logic [NSRC-1:0] s);
    logic [REG_W-1:0] r;
    r           = '0;
    r[P_IRQ_EN] = c.irq_en;
    r[P_DRQ_SL] = c.drq_sel;
    r[P_FAE_EN] = c.fae_en;
    r[P_RDY]    = s[S_RDY];
    r[P_SIF]    = s[S_SIF];
    r[P_DRQ]    = s[S_DRQ];
    r[P_PIN]    = s[S_PIN];
    r[P_FAE]    = s[S_FAE];
    r[P_CRC]    = s[S_CRC];
    return r;
  endfunction
endpackage

// File: rtl/sc_stat_bit.sv
module sc_stat_bit #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o,
  output logic rise_o,
  output logic drop_o
);
  logic q_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      q_q <= RST_VAL;
    else if (set_i)   q_q <= 1'b1;   // set wins
    else if (clr_i)   q_q <= 1'b0;
  end

  assign q_o    = q_q;
  assign rise_o = set_i & ~q_q;
  assign drop_o = clr_i & ~set_i & q_q;

  a_r11_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> q_o);
  a_r11_clear_takes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !set_i) |=> !q_o);
  a_r11_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !set_i) |=> $stable(q_o));
endmodule

// File: rtl/sc_pin_mon.sv
module sc_pin_mon #(
  parameter int unsigned PIN_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [PIN_W-1:0] pins_i,
  output logic             chg_o
);
  logic [PIN_W-1:0] prev_q;
  logic             arm_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= '0;
      arm_q  <= 1'b0;
    end else begin
      prev_q <= pins_i;
      arm_q  <= 1'b1;
    end
  end

  // first sample after reset is a baseline, not a change
  assign chg_o = arm_q & (|(pins_i ^ prev_q));

  a_r7_steady_no_chg: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $stable(pins_i) |=> (!chg_o || !$stable(pins_i)));
endmodule

// File: rtl/sc_irq_pend.sv
module sc_irq_pend #(
  parameter int unsigned N = 6
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] rise_i,
  input  logic [N-1:0] drop_i,
  input  logic         rd_i,
  input  logic         en_i,
  output logic         irq_o
);
  logic [N-1:0] pend_q;
  logic         ack;

  assign ack = rd_i & en_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else         pend_q <= (pend_q & ~drop_i & ~{N{ack}}) | rise_i;
  end

  assign irq_o = en_i & (|pend_q);

  a_r10_read_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && en_i && !(|rise_i)) |=> !(|pend_q));
  a_r3_rise_raises: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|rise_i) |=> (|pend_q));
  a_r13_masked_keeps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !(|drop_i)) |=> ((|pend_q) || !$past(|pend_q)));
endmodule

// File: rtl/sc_irq_status.sv
module sc_irq_status
  import sc_irq_pkg::*;
#(
  parameter int unsigned PIN_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sts_rd_i,
  input  logic             sts_wr_i,
  input  logic [15:0]      wdata_i,
  output logic [15:0]      rdata_o,
  input  logic             cmd_wr_i,
  output logic             cmd_go_o,
  input  logic             cmd_is_read_i,
  input  logic             fifo_wr_i,
  input  logic             fifo_rd_i,
  input  logic             pin_rd_i,
  input  logic             fae_rd_i,
  input  logic             done_i,
  input  logic             sif_i,
  input  logic             drq_i,
  input  logic             fae_i,
  input  logic             crc_err_i,
  input  logic [PIN_W-1:0] pins_i,
  input  logic             dma_en_i,
  output logic             dma_req_o,
  input  logic             bs_i,
  output logic             bs_o,
  output logic             irq_o
);
  ctrl_t           ctrl_q;
  logic [NSRC-1:0] set_v, clr_v, stat_v, rise_v, drop_v;
  logic            pin_chg, cmd_ok, fifo_hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
    end else if (sts_wr_i) begin
      ctrl_q.irq_en  <= wdata_i[P_IRQ_EN];
      ctrl_q.drq_sel <= wdata_i[P_DRQ_SL];
      ctrl_q.fae_en  <= wdata_i[P_FAE_EN];
    end
  end

  sc_pin_mon #(.PIN_W(PIN_W)) u_pin_mon (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .pins_i(pins_i),
    .chg_o (pin_chg)
  );

  // command accepted only while idle
  assign cmd_ok   = cmd_wr_i & stat_v[S_RDY];
  assign cmd_go_o = cmd_ok;
  assign fifo_hit = (fifo_wr_i & ~cmd_is_read_i) | (fifo_rd_i & cmd_is_read_i);

  always_comb begin
    set_v        = '0;
    clr_v        = '0;
    set_v[S_RDY] = done_i | crc_err_i;
    clr_v[S_RDY] = cmd_ok;
    set_v[S_SIF] = sif_i;
    clr_v[S_SIF] = cmd_ok;
    set_v[S_DRQ] = drq_i & ctrl_q.drq_sel;
    clr_v[S_DRQ] = fifo_hit & ctrl_q.drq_sel;
    set_v[S_PIN] = pin_chg;
    clr_v[S_PIN] = pin_rd_i;
    set_v[S_FAE] = fae_i & ctrl_q.fae_en;
    clr_v[S_FAE] = fae_rd_i;
    set_v[S_CRC] = crc_err_i;
    clr_v[S_CRC] = cmd_ok;
  end

  for (genvar g = 0; g < NSRC; g++) begin : g_bit
    sc_stat_bit #(.RST_VAL(SRC_RST[g])) u_bit (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .set_i (set_v[g]),
      .clr_i (clr_v[g]),
      .q_o   (stat_v[g]),
      .rise_o(rise_v[g]),
      .drop_o(drop_v[g])
    );
  end

  sc_irq_pend #(.N(NSRC)) u_pend (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .rise_i(rise_v),
    .drop_i(drop_v),
    .rd_i  (sts_rd_i),
    .en_i  (ctrl_q.irq_en),
    .irq_o (irq_o)
  );

  assign rdata_o   = pack_reg(ctrl_q, stat_v);
  assign dma_req_o = stat_v[S_DRQ] & dma_en_i;
  assign bs_o      = bs_i & ~stat_v[S_CRC];

  a_r2_busy_holds_rdy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rdata_o[P_RDY] && !done_i && !crc_err_i) |=> !rdata_o[P_RDY]);
  a_r2_busy_no_go: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rdata_o[P_RDY] |-> !cmd_go_o);
  a_r9_crc_bus_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    crc_err_i |=> (!bs_o && rdata_o[P_RDY]));
  a_r5_drq_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rdata_o[P_DRQ_SL] && !sts_wr_i) |=> $stable(rdata_o[P_DRQ]));
  a_r8_fae_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rdata_o[P_FAE_EN] && !rdata_o[P_FAE]) |=> !rdata_o[P_FAE]);
  a_r6_dma_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dma_req_o |-> (rdata_o[P_DRQ] && dma_en_i));
endmodule

// File: tb/sc_irq_status_tb.sv
module sc_irq_status_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sts_rd, sts_wr, cmd_wr, cmd_is_read, fifo_wr, fifo_rd;
  logic        pin_rd, fae_rd, done, sif, drq, fae, crc_err, dma_en, bs_in;
  logic [15:0] wdata, rdata;
  logic [1:0]  pins;
  logic        cmd_go, dma_req, bs_out, irq;
  int          n_run = 0, n_fail = 0;

  always #10 clk = ~clk;

  sc_irq_status u_dut (
    .clk_i(clk), .rst_ni(rst_n), .sts_rd_i(sts_rd), .sts_wr_i(sts_wr),
    .wdata_i(wdata), .rdata_o(rdata), .cmd_wr_i(cmd_wr), .cmd_go_o(cmd_go),
    .cmd_is_read_i(cmd_is_read), .fifo_wr_i(fifo_wr), .fifo_rd_i(fifo_rd),
    .pin_rd_i(pin_rd), .fae_rd_i(fae_rd), .done_i(done), .sif_i(sif),
    .drq_i(drq), .fae_i(fae), .crc_err_i(crc_err), .pins_i(pins),
    .dma_en_i(dma_en), .dma_req_o(dma_req), .bs_i(bs_in), .bs_o(bs_out),
    .irq_o(irq)
  );

  // stim bits: 0 done,1 sif,2 drq,3 crc,4 fae,5 cmd,6 sts_rd,7 fifo_wr,8 fifo_rd,9 pin_rd,10 fae_rd
  localparam int NV = 18;
  localparam logic [27:0] VEC [NV] = '{
    {11'h020, 16'hE000, 1'b0},  // R2 accepted command
    {11'h002, 16'hE040, 1'b1},  // R4
    {11'h040, 16'hE040, 1'b0},  // R10 read drops
    {11'h020, 16'hE040, 1'b0},  // R2 busy, ignored
    {11'h004, 16'hE060, 1'b1},  // R5 set
    {11'h100, 16'hE060, 1'b1},  // R5 wrong direction
    {11'h080, 16'hE040, 1'b0},  // R5 cleared
    {11'h001, 16'hE0C0, 1'b1},  // R3
    {11'h040, 16'hE0C0, 1'b0},  // R10
    {11'h020, 16'hE000, 1'b0},  // R2
    {11'h008, 16'hE082, 1'b1},  // R9
    {11'h040, 16'hE082, 1'b0},  // R10
    {11'h010, 16'hE086, 1'b1},  // R8
    {11'h400, 16'hE082, 1'b0},  // R8 clear
    {11'h024, 16'hE020, 1'b1},  // R2 + R5
    {11'h084, 16'hE020, 1'b1},  // R11 set wins
    {11'h040, 16'hE020, 1'b0},  // R10
    {11'h080, 16'hE000, 1'b0}   // R5
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    {sts_rd, sts_wr, cmd_wr, fifo_wr, fifo_rd, pin_rd, fae_rd} = '0;
    {done, sif, drq, fae, crc_err} = '0;
  endtask

  task automatic apply(input logic [10:0] s);
    {fae_rd, pin_rd, fifo_rd, fifo_wr, sts_rd, cmd_wr, fae, crc_err, drq, sif, done} = s;
    @(negedge clk);
    idle();
  endtask

  task automatic wr_ctrl(input logic [15:0] v);
    wdata = v; sts_wr = 1'b1;
    @(negedge clk);
    idle();
  endtask

  initial begin
    #4000000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    idle();
    wdata = '0; cmd_is_read = 1'b0; pins = 2'b00; dma_en = 1'b0; bs_in = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset rdata", rdata, 16'h0080);
    chk("R1 reset irq", irq, 0);
    chk("R1 reset dma", dma_req, 0);

    wr_ctrl(16'hE000);
    chk("R12 ctrl write", rdata, 16'hE080);
    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][27:17]);
      chk($sformatf("vec%0d rdata R2/R3/R4/R5/R8/R9/R10/R11", i), rdata, VEC[i][16:1]);
      chk($sformatf("vec%0d irq R10", i), irq, VEC[i][0]);
    end

    // R13 masked interrupt stays pending across a read
    wr_ctrl(16'h6000);
    apply(11'h001);
    chk("R13 masked rdata", rdata, 16'h6080);
    chk("R13 masked irq", irq, 0);
    apply(11'h040);
    wr_ctrl(16'hE000);
    chk("R13 enable raises", irq, 1);
    apply(11'h040);
    chk("R10 read drops", irq, 0);

    // R5 select gating
    wr_ctrl(16'hA000);
    apply(11'h004);
    chk("R5 drq ignored sel=0", rdata, 16'hA080);
    wr_ctrl(16'hE000);
    apply(11'h004);
    chk("R5 drq set", rdata, 16'hE0A0);
    wr_ctrl(16'hA000);
    apply(11'h080);
    chk("R5 clear ignored sel=0", rdata, 16'hA0A0);
    chk("R6 dma off", dma_req, 0);
    dma_en = 1'b1; #1;
    chk("R6 dma on", dma_req, 1);
    dma_en = 1'b0;
    wr_ctrl(16'hE000);
    apply(11'h040);
    cmd_is_read = 1'b1;
    apply(11'h080);
    chk("R5 wrong dir", rdata, 16'hE0A0);
    apply(11'h100);
    chk("R5 read clears", rdata, 16'hE080);
    cmd_is_read = 1'b0;

    // R8 enable gating
    wr_ctrl(16'hC000);
    apply(11'h010);
    chk("R8 fae gated", rdata, 16'hC080);

    // R7 pin change
    pins = 2'b01;
    @(negedge clk);
    chk("R7 pin set", rdata, 16'hC090);
    chk("R7 pin irq", irq, 1);
    pins = 2'b11;
    apply(11'h200);
    chk("R11 pin set wins", rdata, 16'hC090);
    apply(11'h200);
    chk("R7 pin clear", rdata, 16'hC080);
    chk("R7 irq dropped", irq, 0);

    // R9 crc and bus state
    cmd_wr = 1'b1; #1;
    chk("R2 go pulse", cmd_go, 1);
    @(negedge clk); idle();
    cmd_wr = 1'b1; #1;
    chk("R2 busy no go", cmd_go, 0);
    @(negedge clk); idle();
    chk("R9 bs idle", bs_out, 1);
    apply(11'h008);
    chk("R9 crc rdata", rdata, 16'hC082);
    chk("R9 bs low", bs_out, 0);
    chk("R9 irq", irq, 1);
    apply(11'h020);
    chk("R9 bs restored", bs_out, 1);

    // R12 reserved bits
    wr_ctrl(16'hFFFF);
    chk("R12 reserved zero", rdata, 16'hE000);

    // R11 sif set with accepted command
    apply(11'h001);
    apply(11'h022);
    chk("R11 sif vs cmd", rdata, 16'hE040);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule